// File: doc/BRIEF.md
# Bit-Oriented Code Receive Detector

This block watches the serial data-link bits that a T1 framer pulls out of extended-superframe frames. It looks for repeated 16-bit code words, each carrying a 6-bit message. A message counts as present only after enough back-to-back, correctly spaced copies of the same word have arrived. The host chooses that repetition threshold. After a message has been accepted, the block declares it lost only when no copy of it has been seen for a chosen number of data-link bits.

Acceptance and loss each set a sticky status flag, and the host clears a flag by writing a one to it. The accepted code is held on an output for the host to read. Each flag can be enabled separately to pull a shared active-low interrupt. While the extended-superframe mode input is low, the detector is idle. Framing recovery and extraction of the data-link bits are handled upstream.

Top module: `boc_rx_detect`

## Requirements
- R1: While `esf_en` is 0, data-link strobes are ignored and no detection can occur. Any repetition count or loss timer in progress is discarded, so after `esf_en` returns to 1, counting starts again from zero.
- R2: A code word arrives as 16 strobed bits in this order: a 0, then code bits 5 down to 0, then a 0, then eight 1s. When a message is accepted, `code_out` takes its 6-bit value, with bit 5 being the first code bit received.
- R3: A message is accepted on its Nth consecutive identical word, where N is 1, 3, 5 or 7 for `filt_sel` values 0, 1, 2 or 3. After N-1 words it is not yet accepted.
- R4: While a message is held, the loss event fires on the Lth strobe since the last word that carried the held code, where L is 16, 32, 48 or 64 for `quiet_sel` values 0, 1, 2 or 3. At L-1 strobes it has not yet fired.
- R5: Two words are consecutive only when they are exactly 16 strobes apart and carry the same code. A word with a different code, or one displaced by an extra bit, restarts the count at one.
- R6: `det_flag` is set when a message is accepted and stays set until a one is written to `det_clr`. While the same held message keeps arriving, the flag is not set again. It is set again by a different code, or by any code once the held message has been lost.
- R7: `lost_flag` is set by the loss event and stays set until a one is written to `lost_clr`. Clearing one flag leaves the other unchanged.
- R8: `irq_n` is 0 exactly when (`det_flag` and `det_ien`) or (`lost_flag` and `lost_ien`) is true, and is 1 otherwise.
- R9: If a set event and a clear write reach a flag in the same cycle, the flag ends up set.
- R10: After reset, `det_flag` and `lost_flag` are 0, `code_out` is 0 and `irq_n` is 1. A flag becomes visible on the second rising clock edge after the strobe of the bit that caused its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| esf_en | input | 1 | Enables detection (extended-superframe mode) |
| dl_bit | input | 1 | Data-link bit |
| dl_stb | input | 1 | Marks a valid `dl_bit` for one cycle |
| filt_sel | input | 2 | Repetition threshold select |
| quiet_sel | input | 2 | Loss window select |
| det_clr | input | 1 | Write-one-to-clear for `det_flag` |
| lost_clr | input | 1 | Write-one-to-clear for `lost_flag` |
| det_ien | input | 1 | Lets `det_flag` drive the interrupt |
| lost_ien | input | 1 | Lets `lost_flag` drive the interrupt |
| code_out | output | 6 | Last accepted 6-bit code |
| det_flag | output | 1 | Sticky accept flag |
| lost_flag | output | 1 | Sticky loss flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
All four repetition thresholds are swept, each paired with a different loss window. Every threshold and window is probed one step short of its limit and then at the limit, which separates an off-by-one in the counters from a correct boundary. All 64 code values are sent back to back, which exposes any reordering of bits between the serial word and `code_out`. Further patterns test the restart rules: two codes interleaved, a word shifted by one stray bit, the held code repeated after its flag is cleared, the same code again after a loss, and a mode drop part-way through a count. A clear write timed into the same cycle as a set event shows which one takes priority.

// File: rtl/boc_rx_pkg.sv
package boc_rx_pkg;

    localparam int CODE_W     = 6;
    localparam int FLAG_W     = 8;
    localparam int WORD_W     = FLAG_W + CODE_W + 2;
    localparam int SPC_W      = $clog2(WORD_W + 1);
    localparam int REP_MAX    = 7;
    localparam int CNT_W      = $clog2(REP_MAX + 1);
    localparam int QUIET_UNIT = 16;
    localparam int QUIET_MAX  = 4 * QUIET_UNIT;
    localparam int TMR_W      = $clog2(QUIET_MAX + 1);

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } link_st_e;

    // one received-bit event seen by the counters
    typedef struct packed {
        logic  fresh;   // a bit was shifted in last cycle
        logic  hit;     // the window now holds a framed code word
        code_t code;    // code field of the window
    } word_ev_t;

    // consecutive words needed before acceptance: 1, 3, 5, 7
    function automatic logic [CNT_W-1:0] reps_needed(input logic [1:0] sel);
        return CNT_W'(2 * int'(sel) + 1);
    endfunction

    // bits without the held code before a loss: 16, 32, 48, 64
    function automatic logic [TMR_W-1:0] quiet_limit(input logic [1:0] sel);
        return TMR_W'((int'(sel) + 1) * QUIET_UNIT);
    endfunction

endpackage

// File: rtl/boc_rx_shifter.sv
module boc_rx_shifter
    import boc_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     stb,
    input  logic     bit_in,
    output word_ev_t ev
);
    logic [WORD_W-1:0] win_q;
    logic              fresh_q;
    logic              framed;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            win_q   <= '0;
            fresh_q <= 1'b0;
        end else begin
            fresh_q <= stb;
            if (stb) begin
                win_q <= {win_q[WORD_W-2:0], bit_in};
            end
        end
    end

    // oldest bit 0, code, a 0 separator, then the run of ones
    always_comb begin
        framed  = !win_q[WORD_W-1] && !win_q[FLAG_W] && (&win_q[FLAG_W-1:0]);
        ev.fresh = fresh_q;
        ev.hit   = fresh_q && framed;
        ev.code  = win_q[WORD_W-2 -: CODE_W];
    end

endmodule

// File: rtl/boc_rx_integrator.sv
module boc_rx_integrator
    import boc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  word_ev_t   ev,
    input  logic [1:0] filt_sel,
    input  link_st_e   link_st,
    input  code_t      held_code,
    output logic       det_evt,
    output code_t      det_code
);
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [SPC_W-1:0] spc_q;
    code_t            cand_q;
    logic             aligned;

    always_comb begin
        aligned  = (cnt_q != '0) && (spc_q == SPC_W'(WORD_W - 1)) && (ev.code == cand_q);
        if (aligned) begin
            cnt_nx = (cnt_q == CNT_W'(REP_MAX)) ? cnt_q : cnt_q + CNT_W'(1);
        end else begin
            cnt_nx = CNT_W'(1);
        end
        det_evt  = ev.hit && (cnt_nx >= reps_needed(filt_sel))
                   && ((link_st == ST_IDLE) || (ev.code != held_code));
        det_code = ev.code;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            cand_q <= '0;
            spc_q  <= SPC_W'(WORD_W);
        end else if (ev.hit) begin
            cnt_q  <= cnt_nx;
            cand_q <= ev.code;
            spc_q  <= '0;
        end else if (ev.fresh && spc_q != SPC_W'(WORD_W)) begin
            spc_q  <= spc_q + SPC_W'(1);
        end
    end

    AST_HIT_STARTS_RUN: assert property (@(posedge clk) disable iff (rst)
        (en && ev.hit) |=> (cnt_q != '0 || !$past(en))) else $error("run count lost"); // R5

endmodule

// File: rtl/boc_rx_disint.sv
module boc_rx_disint
    import boc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  word_ev_t   ev,
    input  link_st_e   link_st,
    input  code_t      held_code,
    input  logic       det_evt,
    input  logic [1:0] quiet_sel,
    output logic       lost_evt
);
    logic [TMR_W-1:0] tmr_q, tmr_nx;
    logic             keep;

    always_comb begin
        keep     = ev.hit && (ev.code == held_code);
        tmr_nx   = tmr_q + TMR_W'(1);
        lost_evt = (link_st == ST_HELD) && ev.fresh && !keep && !det_evt
                   && (tmr_nx >= quiet_limit(quiet_sel));
    end

    always_ff @(posedge clk) begin
        if (rst || !en || link_st == ST_IDLE || det_evt || keep) begin
            tmr_q <= '0;
        end else if (ev.fresh) begin
            tmr_q <= lost_evt ? '0 : tmr_nx;
        end
    end

    AST_TMR_UNDER_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ($past(ev.fresh) && $stable(quiet_sel) && link_st == ST_HELD)
            |-> (tmr_q < quiet_limit(quiet_sel))) else $error("loss timer past window"); // R4

endmodule

// File: rtl/boc_rx_detect.sv
module boc_rx_detect
    import boc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              esf_en,
    input  logic              dl_bit,
    input  logic              dl_stb,
    input  logic [1:0]        filt_sel,
    input  logic [1:0]        quiet_sel,
    input  logic              det_clr,
    input  logic              lost_clr,
    input  logic              det_ien,
    input  logic              lost_ien,
    output logic [CODE_W-1:0] code_out,
    output logic              det_flag,
    output logic              lost_flag,
    output logic              irq_n
);
    word_ev_t ev;
    link_st_e link_q;
    code_t    held_q;
    code_t    det_code;
    logic     det_evt;
    logic     lost_evt;

    boc_rx_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .en     (esf_en),
        .stb    (dl_stb),
        .bit_in (dl_bit),
        .ev     (ev)
    );

    boc_rx_integrator u_integ (
        .clk       (clk),
        .rst       (rst),
        .en        (esf_en),
        .ev        (ev),
        .filt_sel  (filt_sel),
        .link_st   (link_q),
        .held_code (held_q),
        .det_evt   (det_evt),
        .det_code  (det_code)
    );

    boc_rx_disint u_disint (
        .clk       (clk),
        .rst       (rst),
        .en        (esf_en),
        .ev        (ev),
        .link_st   (link_q),
        .held_code (held_q),
        .det_evt   (det_evt),
        .quiet_sel (quiet_sel),
        .lost_evt  (lost_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q    <= ST_IDLE;
            held_q    <= '0;
            det_flag  <= 1'b0;
            lost_flag <= 1'b0;
        end else begin
            if (!esf_en) begin
                link_q <= ST_IDLE;
            end else if (det_evt) begin
                link_q <= ST_HELD;
                held_q <= det_code;
            end else if (lost_evt) begin
                link_q <= ST_IDLE;
            end
            det_flag  <= det_evt  || (det_flag  && !det_clr);
            lost_flag <= lost_evt || (lost_flag && !lost_clr);
        end
    end

    assign code_out = held_q;
    assign irq_n    = !((det_flag && det_ien) || (lost_flag && lost_ien));

    AST_IDLE_NO_DET: assert property (@(posedge clk) disable iff (rst)
        !esf_en |=> !det_evt) else $error("detect while idle"); // R1
    AST_CODE_ON_DET: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_out) |-> $past(det_evt)) else $error("code moved without detect"); // R2
    AST_DET_STICKY: assert property (@(posedge clk) disable iff (rst)
        (det_flag && !det_clr) |=> det_flag) else $error("detect flag dropped"); // R6
    AST_LOST_FROM_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_flag) |-> $past(link_q == ST_HELD)) else $error("loss without held code"); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        det_evt |=> det_flag) else $error("clear beat set"); // R9

endmodule

// File: tb/tb_boc_rx_detect.sv
module tb_boc_rx_detect;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       esf_en = 1'b0;
    logic       dl_bit = 1'b0;
    logic       dl_stb = 1'b0;
    logic [1:0] filt_sel = 2'd0;
    logic [1:0] quiet_sel = 2'd3;
    logic       det_clr = 1'b0;
    logic       lost_clr = 1'b0;
    logic       det_ien = 1'b0;
    logic       lost_ien = 1'b0;
    logic [5:0] code_out;
    logic       det_flag;
    logic       lost_flag;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boc_rx_detect dut (
        .clk       (clk),
        .rst       (rst),
        .esf_en    (esf_en),
        .dl_bit    (dl_bit),
        .dl_stb    (dl_stb),
        .filt_sel  (filt_sel),
        .quiet_sel (quiet_sel),
        .det_clr   (det_clr),
        .lost_clr  (lost_clr),
        .det_ien   (det_ien),
        .lost_ien  (lost_ien),
        .code_out  (code_out),
        .det_flag  (det_flag),
        .lost_flag (lost_flag),
        .irq_n     (irq_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        dl_bit = b;
        dl_stb = 1'b1;
        @(negedge clk);
        dl_stb = 1'b0;
    endtask

    // arrival order: 0, c5..c0, 0, eight ones
    function automatic logic word_bit(input logic [5:0] c, input int i);
        if (i == 0 || i == 7) return 1'b0;
        if (i <= 6) return c[6 - i];
        return 1'b1;
    endfunction

    task automatic send_word(input logic [5:0] c);
        for (int i = 0; i < 16; i++) send_bit(word_bit(c, i));
    endtask

    task automatic send_words(input logic [5:0] c, input int n);
        for (int k = 0; k < n; k++) send_word(c);
    endtask

    task automatic send_zeros(input int n);
        for (int k = 0; k < n; k++) send_bit(1'b0);
    endtask

    task automatic clr_flags(input logic d, input logic l);
        @(negedge clk);
        det_clr  = d;
        lost_clr = l;
        @(negedge clk);
        det_clr  = 1'b0;
        lost_clr = 1'b0;
    endtask

    task automatic mode_cycle();
        @(negedge clk);
        esf_en = 1'b0;
        @(negedge clk);
        esf_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R10 reset state
        chk("R10 det_flag", int'(det_flag), 0);
        chk("R10 lost_flag", int'(lost_flag), 0);
        chk("R10 code_out", int'(code_out), 0);
        chk("R10 irq_n", int'(irq_n), 1);
        esf_en = 1'b1;

        // R3 / R4 sweep over every threshold and window
        for (int k = 0; k < 4; k++) begin
            logic [5:0] c;
            int n;
            int lw;
            c  = 6'(k * 13 + 5);
            n  = 2 * k + 1;
            lw = 16 * (4 - k);
            filt_sel  = 2'(k);
            quiet_sel = 2'(3 - k);
            send_words(c, n - 1);
            idle(2);
            chk("R3 below threshold", int'(det_flag), 0);
            send_word(c);
            idle(2);
            chk("R3 at threshold", int'(det_flag), 1);
            chk("R2 code latched", int'(code_out), int'(c));
            send_zeros(lw - 1);
            idle(2);
            chk("R4 before window", int'(lost_flag), 0);
            send_zeros(1);
            idle(2);
            chk("R4 at window", int'(lost_flag), 1);
            clr_flags(1'b1, 1'b1);
        end

        // R2 every code value, back to back
        filt_sel  = 2'd0;
        quiet_sel = 2'd3;
        for (int c = 0; c < 64; c++) begin
            send_word(6'(c));
            idle(2);
            chk("R2 detect per code", int'(det_flag), 1);
            chk("R2 code bit order", int'(code_out), c);
            clr_flags(1'b1, 1'b0);
        end

        // R6 held code repeating does not set the flag again
        filt_sel = 2'd1;
        send_words(6'd63, 3);
        idle(2);
        chk("R6 same code no reset", int'(det_flag), 0);
        send_words(6'd5, 3);
        idle(2);
        chk("R6 new code sets", int'(det_flag), 1);
        chk("R6 new code value", int'(code_out), 5);
        clr_flags(1'b1, 1'b0);
        idle(1);
        chk("R6 cleared", int'(det_flag), 0);
        quiet_sel = 2'd0;
        send_zeros(16);
        idle(2);
        chk("R4 short window", int'(lost_flag), 1);
        clr_flags(1'b0, 1'b1);
        idle(1);
        chk("R7 lost cleared", int'(lost_flag), 0);
        chk("R7 det untouched", int'(det_flag), 0);
        quiet_sel = 2'd3;
        send_words(6'd5, 3);
        idle(2);
        chk("R6 same code after loss", int'(det_flag), 1);
        chk("R6 same code value", int'(code_out), 5);
        clr_flags(1'b1, 1'b0);

        // R5 interleaved code restarts the count
        send_words(6'd9, 2);
        send_words(6'd10, 2);
        idle(2);
        chk("R5 interleave no detect", int'(det_flag), 0);
        send_word(6'd10);
        idle(2);
        chk("R5 third of new code", int'(det_flag), 1);
        chk("R5 new code value", int'(code_out), 10);
        clr_flags(1'b1, 1'b1);

        // R5 stray bit breaks alignment
        send_words(6'd20, 2);
        send_bit(1'b1);
        send_words(6'd20, 2);
        idle(2);
        chk("R5 misaligned no detect", int'(det_flag), 0);
        send_word(6'd20);
        idle(2);
        chk("R5 realigned detect", int'(det_flag), 1);
        clr_flags(1'b1, 1'b1);

        // R1 mode off ignores words
        filt_sel = 2'd0;
        @(negedge clk);
        esf_en = 1'b0;
        send_words(6'd33, 2);
        idle(2);
        chk("R1 idle no detect", int'(det_flag), 0);
        chk("R1 idle code kept", int'(code_out), 20);
        @(negedge clk);
        esf_en = 1'b1;
        filt_sel = 2'd1;
        send_words(6'd33, 2);
        mode_cycle();
        send_word(6'd33);
        idle(2);
        chk("R1 partial count dropped", int'(det_flag), 0);
        send_words(6'd33, 2);
        idle(2);
        chk("R1 count after re-enable", int'(det_flag), 1);
        clr_flags(1'b1, 1'b1);

        // R9 set and clear in the same cycle
        filt_sel = 2'd0;
        for (int i = 0; i < 15; i++) send_bit(word_bit(6'd44, i));
        @(negedge clk);
        dl_bit = 1'b1;
        dl_stb = 1'b1;
        @(negedge clk);
        dl_stb  = 1'b0;
        det_clr = 1'b1;
        @(negedge clk);
        det_clr = 1'b0;
        chk("R9 set wins", int'(det_flag), 1);
        chk("R9 code", int'(code_out), 44);

        // R8 interrupt masking
        clr_flags(1'b0, 1'b1);
        chk("R8 masked", int'(irq_n), 1);
        det_ien = 1'b1;
        idle(1);
        chk("R8 det enabled", int'(irq_n), 0);
        quiet_sel = 2'd0;
        send_zeros(16);
        idle(2);
        clr_flags(1'b1, 1'b0);
        chk("R8 lost masked", int'(irq_n), 1);
        lost_ien = 1'b1;
        idle(1);
        chk("R8 lost enabled", int'(irq_n), 0);
        clr_flags(1'b0, 1'b1);
        chk("R8 both clear", int'(irq_n), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule